// File: doc/BRIEF.md
# Random Generator Interrupt Controller

This block holds the status flags and interrupt logic of a random-number generator peripheral. Three sticky flags record a completed operation, a failed deterministic self-test and a failed certification check. Each flag has its own enable bit and its own write-one-to-clear bit in a control register. The enabled flags combine into a core interrupt bit.

The core interrupt bit and a bus slave-error bit sit in a top-level interrupt status register. A mask register gates that register onto one registered interrupt line. Software cannot write the mask directly: it clears mask bits through an enable register and sets them through a disable register. Fault events are gated. They are accepted only while the generator is out of reset, its entropy source is enabled and its oscillator is running. On builds whose version parameter is below 0x0200, a certification fault also needs an explicit fault-unit enable. The random datapath itself is outside this block.

Top module: `rng_irq_ctrl`

## Requirements
- R1: After reset the status flags read 000, the interrupt status reads 00, the mask reads 11 and the interrupt line is low.
- R2: The event inputs set sticky flags on the `statusFlags` port: bit 0 is done, bit 1 is test fault, bit 2 is certification fault. Each flag stays set after its event pulse ends.
- R3: A write to word address 0 (control) loads the enables for done, test fault and certification fault from data bits 0, 1 and 2. The same write clears those flags for each 1 in data bits 3, 4 and 5.
- R4: Interrupt status bit 0 (core) is set to the OR of (flag AND enable) whenever a control write or an accepted event occurs. This also happens when the flags themselves do not change.
- R5: Interrupt status (word address 1) is write-one-to-clear on bit 0 (core) and bit 1 (slave error). A pulse on `slvErrEvt` sets bit 1.
- R6: Writing 1s to word address 2 clears those mask bits, and writing 1s to word address 3 sets them. When neither register is written, the mask holds.
- R7: The interrupt line equals the OR of (status AND NOT mask) one cycle after those registers take their values.
- R8: The two fault events are ignored while `blkRst` is high, `entropyEn` is low or `oscEn` is low.
- R9: With `HW_VERSION` below 0x0200, a certification fault is ignored unless `certUnitEn` is high. From 0x0200 upward, `certUnitEn` has no effect.
- R10: A `softRst` pulse clears all three flags and the core status bit and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | DATA_W | Write data |
| doneEvt | input | 1 | Generation-complete event |
| faultTest | input | 1 | Deterministic-test fault event |
| faultCert | input | 1 | Certification fault event |
| slvErrEvt | input | 1 | Bus slave-error event |
| softRst | input | 1 | Generator soft reset |
| blkRst | input | 1 | Generator held in reset |
| entropyEn | input | 1 | Entropy source enable |
| oscEn | input | 1 | Oscillator enable |
| certUnitEn | input | 1 | Explicit certification-unit enable (older versions) |
| statusFlags | output | 3 | Sticky flags {cert, test, done} |
| isrBits | output | 2 | Interrupt status {slave error, core} |
| maskBits | output | 2 | Interrupt mask |
| irqOut | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is the legacy certification gate. It appears only in a build whose version parameter is below 0x0200. The bench therefore instantiates a second, legacy copy of the block. Both copies get the same stimulus, including a certification fault with the unit enable low. The bench expects the flag in the current build and no flag in the legacy one. A second case is a control write that changes only the enables. It raises the core bit without any new event. The bench reaches it by leaving a test-fault flag standing with its enable low and then writing the enable alone.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
  localparam int FLAG_N = 3;
  localparam int ISR_N  = 2;

  // Control register field positions
  localparam int EN_LSB  = 0;
  localparam int CLR_LSB = 3;
  localparam int CTRL_W  = CLR_LSB + FLAG_N;

  // Word addresses
  localparam int CTRL_IDX = 0;
  localparam int ISR_IDX  = 1;
  localparam int IER_IDX  = 2;
  localparam int IDR_IDX  = 3;

  typedef struct packed {
    logic              ctrlWr;
    logic [CTRL_W-1:0] ctrlData;
    logic [FLAG_N-1:0] flagSet;
    logic [ISR_N-1:0]  isrClr;
    logic [ISR_N-1:0]  maskClr;
    logic [ISR_N-1:0]  maskSet;
    logic              softClr;
    logic              slvErrSet;
  } strobe_t;
endpackage

// File: rtl/rng_irq_ctrl_dec.sv
module rng_irq_ctrl_dec
  import rng_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int HW_VERSION = 32'h0200
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              doneEvt,
  input  logic              faultTest,
  input  logic              faultCert,
  input  logic              slvErrEvt,
  input  logic              softRst,
  input  logic              blkRst,
  input  logic              entropyEn,
  input  logic              oscEn,
  input  logic              certUnitEn,
  output strobe_t           strobe
);
  localparam bit LEGACY = (HW_VERSION < 32'h0200);

  logic srcOn;
  logic certOk;
  logic hitCtrl, hitIsr, hitIer, hitIdr;

  always_comb begin
    srcOn   = !blkRst && entropyEn && oscEn;
    certOk  = srcOn && (!LEGACY || certUnitEn);
    hitCtrl = wrEn && (wrAddr == ADDR_W'(CTRL_IDX));
    hitIsr  = wrEn && (wrAddr == ADDR_W'(ISR_IDX));
    hitIer  = wrEn && (wrAddr == ADDR_W'(IER_IDX));
    hitIdr  = wrEn && (wrAddr == ADDR_W'(IDR_IDX));

    strobe.ctrlWr    = hitCtrl;
    strobe.ctrlData  = wrData[CTRL_W-1:0];
    strobe.flagSet   = {faultCert && certOk, faultTest && srcOn, doneEvt && !blkRst};
    strobe.isrClr    = hitIsr ? wrData[ISR_N-1:0] : '0;
    strobe.maskClr   = hitIer ? wrData[ISR_N-1:0] : '0;
    strobe.maskSet   = hitIdr ? wrData[ISR_N-1:0] : '0;
    strobe.softClr   = softRst;
    strobe.slvErrSet = slvErrEvt;
  end
endmodule

// File: rtl/rng_irq_datapath.sv
module rng_irq_datapath
  import rng_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic [FLAG_N-1:0] flagQ,
  output logic [ISR_N-1:0]  isrQ,
  output logic [ISR_N-1:0]  maskQ,
  output logic              irqQ
);
  logic [FLAG_N-1:0] enQ, enNext, flagNext, clrBits;
  logic [ISR_N-1:0]  isrNext, maskNext;
  logic              coreNext, recompute;

  always_comb begin
    clrBits   = strobe.ctrlWr ? strobe.ctrlData[CLR_LSB +: FLAG_N] : '0;
    enNext    = strobe.ctrlWr ? strobe.ctrlData[EN_LSB +: FLAG_N] : enQ;
    flagNext  = strobe.softClr ? '0 : ((flagQ & ~clrBits) | strobe.flagSet);
    coreNext  = |(flagNext & enNext);
    recompute = strobe.ctrlWr || (|strobe.flagSet);

    if (strobe.softClr)      isrNext[0] = 1'b0;
    else if (recompute)      isrNext[0] = coreNext;
    else if (strobe.isrClr[0]) isrNext[0] = 1'b0;
    else                     isrNext[0] = isrQ[0];

    if (strobe.slvErrSet)      isrNext[1] = 1'b1;
    else if (strobe.isrClr[1]) isrNext[1] = 1'b0;
    else                       isrNext[1] = isrQ[1];

    maskNext = (maskQ & ~strobe.maskClr) | strobe.maskSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      isrQ  <= '0;
      maskQ <= '1;
      irqQ  <= 1'b0;
    end else begin
      flagQ <= flagNext;
      enQ   <= enNext;
      isrQ  <= isrNext;
      maskQ <= maskNext;
      irqQ  <= |(isrQ & ~maskQ);
    end
  end
endmodule

// File: rtl/rng_irq_ctrl.sv
module rng_irq_ctrl
  import rng_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int HW_VERSION = 32'h0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              doneEvt,
  input  logic              faultTest,
  input  logic              faultCert,
  input  logic              slvErrEvt,
  input  logic              softRst,
  input  logic              blkRst,
  input  logic              entropyEn,
  input  logic              oscEn,
  input  logic              certUnitEn,
  output logic [2:0]        statusFlags,
  output logic [1:0]        isrBits,
  output logic [1:0]        maskBits,
  output logic              irqOut
);
  strobe_t strobe;

  rng_irq_ctrl_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HW_VERSION(HW_VERSION)) i_dec (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .doneEvt(doneEvt), .faultTest(faultTest), .faultCert(faultCert),
    .slvErrEvt(slvErrEvt), .softRst(softRst), .blkRst(blkRst),
    .entropyEn(entropyEn), .oscEn(oscEn), .certUnitEn(certUnitEn),
    .strobe(strobe)
  );

  rng_irq_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .flagQ(statusFlags), .isrQ(isrBits), .maskQ(maskBits), .irqQ(irqOut)
  );
endmodule

// File: rtl/rng_irq_chk.sv
module rng_irq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              softRst,
  input logic              blkRst,
  input logic              entropyEn,
  input logic              oscEn,
  input logic [2:0]        statusFlags,
  input logic [1:0]        isrBits,
  input logic [1:0]        maskBits,
  input logic              irqOut
);
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(isrBits & ~maskBits))));

  p_soft_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (statusFlags == 3'b000) && !isrBits[0]);

  p_fault_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (blkRst || !entropyEn || !oscEn) |=>
      ((statusFlags[2:1] & ~$past(statusFlags[2:1])) == 2'b00));

  p_mask_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(maskBits));

  p_mask_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == ADDR_W'(0) || wrAddr == ADDR_W'(1))) |=> $stable(maskBits));
endmodule

bind rng_irq_ctrl rng_irq_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_rng_irq_ctrl.sv
module test_rng_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic doneEvt = 1'b0, faultTest = 1'b0, faultCert = 1'b0, slvErrEvt = 1'b0;
  logic softRst = 1'b0, blkRst = 1'b0, entropyEn = 1'b0, oscEn = 1'b0, certUnitEn = 1'b0;
  logic [2:0] statusFlags, legFlags;
  logic [1:0] isrBits, maskBits, legIsr, legMask;
  logic irqOut, legIrq;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rng_irq_ctrl i_rng_irq_ctrl (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .doneEvt, .faultTest, .faultCert,
    .slvErrEvt, .softRst, .blkRst, .entropyEn, .oscEn, .certUnitEn,
    .statusFlags, .isrBits, .maskBits, .irqOut
  );

  rng_irq_ctrl #(.HW_VERSION(32'h0100)) i_rng_irq_ctrl_legacy (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .doneEvt, .faultTest, .faultCert,
    .slvErrEvt, .softRst, .blkRst, .entropyEn, .oscEn, .certUnitEn,
    .statusFlags(legFlags), .isrBits(legIsr), .maskBits(legMask), .irqOut(legIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic t_reset();
    check("R1 flags", 32'(statusFlags), 32'h0);
    check("R1 isr", 32'(isrBits), 32'h0);
    check("R1 mask", 32'(maskBits), 32'h3);
    check("R1 irq", 32'(irqOut), 32'h0);
  endtask

  task automatic t_events();
    entropyEn = 1; oscEn = 1; blkRst = 0; certUnitEn = 0;
    faultTest = 1; tick(); faultTest = 0; tick();
    check("R2 test flag", 32'(statusFlags), 32'h2);
    doneEvt = 1; tick(); doneEvt = 0;
    check("R2 done flag", 32'(statusFlags), 32'h3);
    faultCert = 1; tick(); faultCert = 0;
    check("R2 cert flag", 32'(statusFlags), 32'h7);
    check("R9 legacy cert blocked", 32'(legFlags), 32'h3);
    certUnitEn = 1; faultCert = 1; tick(); faultCert = 0; certUnitEn = 0;
    check("R9 legacy cert with unit enable", 32'(legFlags), 32'h7);
  endtask

  task automatic t_clear();
    wr(4'd0, 32'h28);
    check("R3 clear done and cert", 32'(statusFlags), 32'h2);
    check("R4 no enable no core", 32'(isrBits), 32'h0);
  endtask

  task automatic t_core();
    wr(4'd0, 32'h02);
    check("R4 enable raises core", 32'(isrBits), 32'h1);
    tick();
    check("R7 masked irq low", 32'(irqOut), 32'h0);
    wr(4'd2, 32'h1);
    check("R6 enable clears mask bit", 32'(maskBits), 32'h2);
    check("R7 irq lags", 32'(irqOut), 32'h0);
    tick();
    check("R7 irq high", 32'(irqOut), 32'h1);
  endtask

  task automatic t_w1c();
    wr(4'd1, 32'h1);
    check("R5 core w1c", 32'(isrBits), 32'h0);
    tick();
    check("R7 irq drops", 32'(irqOut), 32'h0);
    slvErrEvt = 1; tick(); slvErrEvt = 0;
    check("R5 slave error set", 32'(isrBits), 32'h2);
    wr(4'd2, 32'h2);
    check("R6 mask cleared", 32'(maskBits), 32'h0);
    tick();
    check("R7 slave error irq", 32'(irqOut), 32'h1);
    wr(4'd3, 32'h3);
    check("R6 disable sets mask", 32'(maskBits), 32'h3);
    tick();
    check("R7 masked again", 32'(irqOut), 32'h0);
    wr(4'd1, 32'h2);
    check("R5 slave error w1c", 32'(isrBits), 32'h0);
  endtask

  task automatic t_gate();
    wr(4'd0, 32'h12);
    check("R3 clear test flag", 32'(statusFlags), 32'h0);
    oscEn = 0; faultTest = 1; tick(); faultTest = 0;
    check("R8 oscillator off", 32'(statusFlags), 32'h0);
    oscEn = 1; entropyEn = 0; faultTest = 1; tick(); faultTest = 0;
    check("R8 entropy off", 32'(statusFlags), 32'h0);
    entropyEn = 1; blkRst = 1; faultCert = 1; tick(); faultCert = 0;
    check("R8 in reset", 32'(statusFlags), 32'h0);
    blkRst = 0; faultTest = 1; tick(); faultTest = 0;
    check("R8 accepted when enabled", 32'(statusFlags), 32'h2);
    check("R4 event recompute", 32'(isrBits), 32'h1);
  endtask

  task automatic t_soft();
    softRst = 1; tick(); softRst = 0;
    check("R10 flags cleared", 32'(statusFlags), 32'h0);
    check("R10 core cleared", 32'(isrBits), 32'h0);
    check("R10 mask kept", 32'(maskBits), 32'h3);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_events();
    t_clear();
    t_core();
    t_w1c();
    t_gate();
    t_soft();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule